// File: doc/BRIEF.md
# Instruction Memory Sequencer

This block drives two single-port synchronous memories and the input of a small automaton. It has two modes.

In load mode a host hands it 3-bit instruction words, one for each cycle in which `load_valid` is high. The block keeps its own write pointer, so the host never gives an address. Each word lands at the next free location of the instruction memory.

A one-cycle `start` pulse switches it to run mode. It then reads the instruction memory from address zero, one location per cycle. Every word that is not a halt is passed to the automaton. The log opcode also stores the automaton's output in a result memory, at a second pointer that advances on its own. A halt word ends the run, raises `done` and returns the block to load mode.

The instruction memory has a read latency of one cycle. The fetch therefore runs one address ahead of the decode. A valid flag makes sure each word is decoded once, in address order. The memories and the automaton sit outside the block. The block itself holds the pointers, the mode flag and the decoder.

Top module: `imem_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the block in load mode. After the reset edge: `imem_we`=1, `imem_addr`=0, `auto_in`=0, `done`=0 and `rmem_we`=0.
- R2: In load mode, `load_word` is presented on `imem_wdata` and `imem_addr` shows the write pointer. Each edge with `load_valid`=1 stores the word and moves `imem_addr` up by one. With `load_valid`=0, `imem_addr` holds.
- R3: The edge that samples `start`=1 does four things: `imem_we` drops to 0, the fetch pointer (`imem_addr`) and the result pointer are cleared, and `done` is cleared. The first logged word after a start therefore goes to `rmem_addr`=0.
- R4: In run mode, `imem_addr` rises by one on every edge. The start edge is edge 0, and the word at address k is decoded at edge k+2. No word is skipped or decoded twice.
- R5: A decoded word whose bit 2 is 1 is a halt. After that edge: `done`=1, `imem_we`=1 and `imem_addr`=0, because the write pointer restarts at zero. The halt word and any word fetched behind it are not passed to `auto_in`.
- R6: A decoded word equal to 3'b010 is passed to `auto_in`. On the cycle after its decode edge, `rmem_we` is 1 for exactly one cycle. In that cycle `rmem_addr` holds the current result pointer and `rmem_wdata` holds `auto_out` as sampled at the decode edge. The result pointer then rises by one.
- R7: Any other decoded word with bit 2 equal to 0 is passed to `auto_in` and writes nothing to the result memory.
- R8: `rmem_we` and `imem_we` are never both 1.
- R9: `load_valid` and `load_word` have no effect in run mode: `imem_we` stays 0 and the instruction memory keeps its contents.
- R10: A reset during a run aborts it, restoring the R1 state even on an edge where a halt would have been decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| load_valid | input | 1 | Host word valid in load mode |
| load_word | input | IW | Host instruction word |
| imem_we | output | 1 | Instruction memory write enable, high in load mode |
| imem_addr | output | PW | Instruction memory address: write pointer in load mode, fetch pointer in run mode |
| imem_wdata | output | IW | Instruction memory write data |
| imem_rdata | input | IW | Instruction memory read data, one cycle latency |
| auto_in | output | IW | Registered automaton input |
| auto_out | input | RW | Automaton output |
| rmem_we | output | 1 | Result memory write strobe |
| rmem_addr | output | PW | Result memory address |
| rmem_wdata | output | RW | Result memory write data |
| done | output | 1 | Set by a halt, cleared by start or reset |

## Verification
Counting from the start edge as edge 0, the first fetch address appears after edge 0. The word at address k takes effect after edge k+2. A logged result appears on the result port after that same edge and reaches the result memory one edge later. A halt shows on `done` and `imem_we` right after its decode edge. The bench drives and samples 1 ns after each rising edge and counts edges from the start pulse. It checks the address at every run cycle, expects `done` on exactly edge k+2 of the halt word, and checks the result strobe and data on the exact cycle after a log decode. Memory contents are checked only once the write edge has passed.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Action selected by one decoded instruction word
  typedef enum logic [1:0] {
    OPK_FWD  = 2'd0,
    OPK_LOG  = 2'd1,
    OPK_HALT = 2'd2
  } opk_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode #(
  parameter int IW = 3,
  parameter logic [IW-1:0] LOG_CODE = 3'b010
) (
  input  logic [IW-1:0] word,
  output seq_pkg::opk_t kind
);
  // The top bit has priority: any word with it set is a halt
  always_comb begin
    if (word[IW-1])            kind = seq_pkg::OPK_HALT;
    else if (word == LOG_CODE) kind = seq_pkg::OPK_LOG;
    else                       kind = seq_pkg::OPK_FWD;
  end
endmodule

// File: rtl/seq_ptr.sv
module seq_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end
endmodule

// File: rtl/imem_sequencer.sv
module imem_sequencer #(
  parameter int IW = 3,
  parameter int RW = 4,
  parameter int PW = 16,
  parameter logic [IW-1:0] LOG_CODE = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          load_valid,
  input  logic [IW-1:0] load_word,
  output logic          imem_we,
  output logic [PW-1:0] imem_addr,
  output logic [IW-1:0] imem_wdata,
  input  logic [IW-1:0] imem_rdata,
  output logic [IW-1:0] auto_in,
  input  logic [RW-1:0] auto_out,
  output logic          rmem_we,
  output logic [PW-1:0] rmem_addr,
  output logic [RW-1:0] rmem_wdata,
  output logic          done
);
  import seq_pkg::*;

  logic          run_q;      // 0: load mode, 1: run mode
  logic          fetch_vld;  // imem_rdata holds a fetched word
  opk_t          kind;
  logic          halt_now, log_now, fwd_now;
  logic [PW-1:0] wp, ip, rp;

  seq_decode #(.IW(IW), .LOG_CODE(LOG_CODE)) u_dec (
    .word (imem_rdata),
    .kind (kind)
  );

  // Decode only acts on a word fetched in the previous cycle of this run
  always_comb begin
    halt_now = run_q && fetch_vld && !start && (kind == OPK_HALT);
    log_now  = run_q && fetch_vld && !start && (kind == OPK_LOG);
    fwd_now  = run_q && fetch_vld && !start && (kind != OPK_HALT);
  end

  // Write pointer: load mode only, restarts after a halt
  seq_ptr #(.W(PW)) u_wp (
    .clk (clk), .rst (rst), .clr (halt_now),
    .inc (!run_q && load_valid && !start),
    .q   (wp)
  );

  // Fetch pointer: one address per run cycle, runs ahead of decode
  seq_ptr #(.W(PW)) u_ip (
    .clk (clk), .rst (rst), .clr (start),
    .inc (run_q && !halt_now && !start),
    .q   (ip)
  );

  // Result pointer: one step per logged word
  seq_ptr #(.W(PW)) u_rp (
    .clk (clk), .rst (rst), .clr (start),
    .inc (log_now),
    .q   (rp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      fetch_vld <= 1'b0;
      done      <= 1'b0;
    end else if (start) begin
      run_q     <= 1'b1;
      fetch_vld <= 1'b0;
      done      <= 1'b0;
    end else if (halt_now) begin
      run_q     <= 1'b0;
      fetch_vld <= 1'b0;
      done      <= 1'b1;
    end else begin
      fetch_vld <= run_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          auto_in <= '0;
    else if (fwd_now) auto_in <= imem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rmem_we    <= 1'b0;
      rmem_addr  <= '0;
      rmem_wdata <= '0;
    end else begin
      rmem_we <= log_now;
      if (log_now) begin
        rmem_addr  <= rp;
        rmem_wdata <= auto_out;
      end
    end
  end

  assign imem_we    = !run_q;
  assign imem_addr  = run_q ? ip : wp;
  assign imem_wdata = load_word;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          load_valid,
  input logic          imem_we,
  input logic [PW-1:0] imem_addr,
  input logic          rmem_we,
  input logic [PW-1:0] rmem_addr,
  input logic          done
);
  AST_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rmem_we && imem_we)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!imem_we && imem_addr == '0 && !done)); // R3

  AST_LOAD_ADV: assert property (@(posedge clk) disable iff (rst)
    (imem_we && load_valid && !start) |=> (imem_addr == $past(imem_addr) + 1'b1)); // R2

  AST_RUN_ADV: assert property (@(posedge clk) disable iff (rst)
    (!imem_we && $past(!imem_we) && !$past(start)) |-> (imem_addr == $past(imem_addr) + 1'b1)); // R4

  AST_DONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    done |-> imem_we); // R5

  AST_LOG_STEP: assert property (@(posedge clk) disable iff (rst)
    (rmem_we && $past(rmem_we)) |-> (rmem_addr == $past(rmem_addr) + 1'b1)); // R6
endmodule

bind imem_sequencer seq_chk #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .load_valid (load_valid),
  .imem_we    (imem_we),
  .imem_addr  (imem_addr),
  .rmem_we    (rmem_we),
  .rmem_addr  (rmem_addr),
  .done       (done)
);

// File: tb/imem_sequencer_tb.sv
module imem_sequencer_tb;
  localparam int IW = 3, RW = 4, PW = 16, DEPTH = 64;
  localparam int NPROG = 8, NLOG = 3, HALT_AT = 6;
  // Program words and the results they must log (automaton out = {in,1})
  localparam logic [IW-1:0] PROG [NPROG] = '{3'd1, 3'd2, 3'd0, 3'd3, 3'd2, 3'd2, 3'd6, 3'd1};
  localparam logic [RW-1:0] EXP_LOG [NLOG] = '{4'd3, 4'd7, 4'd5};

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst, start, load_valid;
  logic [IW-1:0] load_word, imem_wdata, imem_rdata, auto_in;
  logic [RW-1:0] auto_out, rmem_wdata;
  logic [PW-1:0] imem_addr, rmem_addr;
  logic imem_we, rmem_we, done;

  imem_sequencer #(.IW(IW), .RW(RW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .load_valid(load_valid), .load_word(load_word),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata), .imem_rdata(imem_rdata),
    .auto_in(auto_in), .auto_out(auto_out),
    .rmem_we(rmem_we), .rmem_addr(rmem_addr), .rmem_wdata(rmem_wdata), .done(done)
  );

  // Bench models: two single-port memories (read-first) and the automaton
  logic [IW-1:0] imem [DEPTH];
  logic [RW-1:0] rmem [DEPTH];
  always @(posedge clk) begin
    if (imem_we) imem[imem_addr[5:0]] <= imem_wdata;
    imem_rdata <= imem[imem_addr[5:0]];
    if (rmem_we) rmem[rmem_addr[5:0]] <= rmem_wdata;
  end
  assign auto_out = {auto_in, 1'b1};

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    int pulses, halt_edge;
    for (int i = 0; i < DEPTH; i++) begin imem[i] = '0; rmem[i] = '0; end
    rst = 1'b1; start = 1'b0; load_valid = 1'b0; load_word = '0;
    step; step;
    // R1 reset state
    chk(imem_we == 1'b1, "R1 imem_we", imem_we, 1);
    chk(imem_addr == 0, "R1 imem_addr", imem_addr, 0);
    chk(auto_in == 0, "R1 auto_in", auto_in, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rmem_we == 1'b0, "R1 rmem_we", rmem_we, 0);
    rst = 1'b0;

    // R2 table-driven load
    for (int i = 0; i < NPROG; i++) begin
      load_word = PROG[i]; load_valid = 1'b1;
      step;
      chk(imem_addr == i + 1, "R2 load advance", imem_addr, i + 1);
    end
    load_valid = 1'b0; load_word = '0;
    step; step;
    chk(imem_addr == NPROG, "R2 hold", imem_addr, NPROG);
    for (int i = 0; i < NPROG; i++)
      chk(imem[i] == PROG[i], "R2 stored word", imem[i], PROG[i]);

    // Run 1
    start = 1'b1; step; start = 1'b0;
    chk(imem_we == 1'b0, "R3 read mode", imem_we, 0);
    chk(imem_addr == 0, "R3 ptr clear", imem_addr, 0);
    chk(done == 1'b0, "R3 done low", done, 0);
    step;
    chk(imem_addr == 1, "R4 first fetch", imem_addr, 1);
    pulses = 0; halt_edge = 0;
    for (int k = 2; k <= 20; k++) begin
      step;
      if (rmem_we) pulses++;
      if (done) begin halt_edge = k; break; end
      chk(imem_addr == k, "R4 run address", imem_addr, k);
    end
    chk(halt_edge == HALT_AT + 2, "R4 halt edge", halt_edge, HALT_AT + 2);
    chk(pulses == NLOG, "R7 log count", pulses, NLOG);
    chk(imem_we == 1'b1, "R5 back to load", imem_we, 1);
    chk(imem_addr == 0, "R5 write ptr zero", imem_addr, 0);
    chk(auto_in == 3'd2, "R5 no forward of halt", auto_in, 2);
    step;
    for (int i = 0; i < NLOG; i++)
      chk(rmem[i] == EXP_LOG[i], "R6 logged value", rmem[i], EXP_LOG[i]);

    // Run 2: log at restart address, host words ignored while running
    load_valid = 1'b1; load_word = 3'd2; step;
    load_word = 3'd4; step;
    load_valid = 1'b0; load_word = '0; step;
    start = 1'b1; step; start = 1'b0;
    chk(done == 1'b0, "R3 done cleared", done, 0);
    load_valid = 1'b1; load_word = 3'd5;
    step; step;
    chk(rmem_we == 1'b1, "R6 strobe", rmem_we, 1);
    chk(rmem_addr == 0, "R3 result ptr clear", rmem_addr, 0);
    chk(rmem_wdata == 4'd5, "R6 data", rmem_wdata, 5);
    chk(imem_we == 1'b0, "R9 no write", imem_we, 0);
    step;
    chk(done == 1'b1, "R5 done", done, 1);
    chk(rmem_we == 1'b0, "R6 single pulse", rmem_we, 0);
    chk(imem[0] == 3'd2, "R9 mem0", imem[0], 2);
    chk(imem[1] == 3'd4, "R9 mem1", imem[1], 4);
    chk(imem[2] == 3'd0, "R9 mem2", imem[2], 0);
    load_valid = 1'b0; load_word = '0;

    // Run 3: reset on the halt decode edge
    step;
    start = 1'b1; step; start = 1'b0;
    step; step;
    rst = 1'b1; step;
    chk(imem_we == 1'b1, "R10 imem_we", imem_we, 1);
    chk(imem_addr == 0, "R10 imem_addr", imem_addr, 0);
    chk(done == 1'b0, "R10 done", done, 0);
    chk(auto_in == 0, "R10 auto_in", auto_in, 0);
    chk(rmem_we == 1'b0, "R10 rmem_we", rmem_we, 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule